// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block carries out one NAND flash transaction under software control. A start pulse latches a set of inputs: the first and second command bytes, a 32-bit address, an 8-bit control field with four reserved bits above it, a data length, and a 32-bit write word. The sequencer then builds the bus sequence from independent stage enables. The available stages are a first command, an address stage of one to four bytes, a data stage in either direction, a second command followed by a wait for the ready line, and a closing status read.

Data for the data stage passes through one of two routes. The first is a 32-bit data word that holds up to four bytes. The second is a pair of byte FIFOs: the host fills one for writes and drains the other for reads. When a FIFO cannot supply or accept a byte, the sequencer holds the bus idle until it can. Each transaction ends with a one-cycle done pulse. The captured status byte and an error flag are presented at that point.

The block drives an 8-bit bus with command latch, address latch, write strobe, read strobe and chip enable, and it samples the ready/busy line through a two-stage synchronizer.

Top module: `nand_cmd_seq`

## Requirements
- R1: Command bytes are driven with `cle` high and `ale` low. Address bytes are driven with `ale` high and `cle` low. Each written byte gets one `we_n` low pulse of at least two clocks. Each read byte gets one `re_n` low pulse of at least two clocks and is sampled at the clock where `re_n` returns high.
- R2: Control bit 0 enables the address stage, and 0 skips that stage. Bits [2:1] set the byte count: 00 gives one byte, 01 two, 10 three and 11 four. Address bytes go out least significant byte first from `addr_i`.
- R3: Control bit 3 enables the second command. When set, `cmd2_i` is issued with `cle`. The bus then stays idle for a fixed delay and for as long as `rb_n` is low. When clear, neither the second command nor the wait takes place.
- R4: Control bit 4 adds a status read as the last stage. It issues command 0x70 and reads one byte into `status_o`. `err_o` is set when bit 0 of that byte is 1. When bit 4 is clear, no 0x70 is issued and `status_o`/`err_o` stay 0.
- R5: Control bit 5 selects the direction: 0 is read and 1 is write. Write order is first command, address, data, second command, wait, status. Read order is first command, address, second command, wait, data, status.
- R6: Control bit 6 selects the data route. With 0, the data word is used: write bytes are taken from `dreg_wdata_i` and read bytes are placed in `dreg_rdata_o`, byte 0 in bits [7:0], and the count is limited to 4. With 1, the write FIFO or the read FIFO is used, in order.
- R7: Control bit 7 enables the data stage. The stage moves `len_i`+1 bytes, which gives 1 to 16 bytes.
- R8: The data stage stalls with no strobe while the write FIFO is empty on a write or the read FIFO is full on a read. It resumes when the host pushes or pops.
- R9: `busy_o` rises the cycle after an accepted start and stays high through the single-cycle `done_o` pulse. A start that arrives while busy is ignored.
- R10: Control bits [11:8] are reserved and have no effect on the bus sequence or the results.
- R11: After reset the block is idle: `busy_o`, `done_o`, `cle`, `ale` and `err_o` are 0, `we_n`, `re_n` and `ce_n` are 1, and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| cmd1_i | input | 8 | First command byte |
| cmd2_i | input | 8 | Second command byte |
| addr_i | input | 32 | Address bytes, byte 0 first |
| ctl_i | input | 12 | Stage enables and selects; [11:8] reserved |
| len_i | input | 4 | Data byte count minus one |
| dreg_wdata_i | input | 32 | Data word for register-route writes |
| dreg_rdata_o | output | 32 | Data word filled by register-route reads |
| wf_push_i | input | 1 | Push a byte into the write FIFO |
| wf_data_i | input | 8 | Write FIFO byte |
| wf_full_o | output | 1 | Write FIFO full |
| rf_pop_i | input | 1 | Pop a byte from the read FIFO |
| rf_data_o | output | 8 | Read FIFO head byte |
| rf_empty_o | output | 1 | Read FIFO empty |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| status_o | output | 8 | Captured status byte |
| err_o | output | 1 | Status bit 0 was set |
| io_out | output | 8 | Bus byte driven toward flash |
| io_oe | output | 1 | Bus output enable |
| io_in | input | 8 | Bus byte from flash |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| ce_n | output | 1 | Chip enable, active low |
| rb_n | input | 1 | Ready (1) / busy (0) from flash |

## Verification
The bench drives the ready line low after each second command and counts any read strobe that falls while the line is low. A sequencer that skipped or shortened the wait would read data early and be caught by this count. It stops the host FIFOs partway through a transfer. A design that ignored full or empty would issue a ninth read into a full FIFO or clock out a stale write byte, and both would show up in the strobe count and the byte log. It also checks the four-byte limit of the register route, low-byte-first address order with one to four bytes, and reserved bits set to all ones. Errors in these would appear as extra, reordered or missing bus bytes. Finally, it pulses start in mid-transaction, where a design that re-latched its inputs would emit a second command sequence.

// File: rtl/nfc_pkg.sv
// Shared types for the NAND command sequencer.
// Assumes: control field is 8 functional bits with the address enable at bit 0.
package nfc_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_DATW, S_CMD2, S_WBDLY,
        S_WAITRB, S_DATR, S_STCMD, S_STRD, S_FIN
    } seq_state_t;

    // Packed: first member is the most significant bit.
    typedef struct packed {
        logic       data_en;   // bit 7
        logic       buf_fifo;  // bit 6
        logic       dir_wr;    // bit 5
        logic       stat_en;   // bit 4
        logic       cmd2_en;   // bit 3
        logic [1:0] addr_cnt;  // bits 2:1
        logic       addr_en;   // bit 0
    } ctl_t;

    localparam logic [7:0] STATUS_CMD = 8'h70;

endpackage

// File: rtl/nfc_fifo.sv
// Byte FIFO with head word visible on dout (first-word fall-through).
// Assumes DEPTH is a power of two; push when full and pop when empty are dropped.
module nfc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; the array itself needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));

endmodule

// File: rtl/nfc_bus_phy.sv
// Byte strobe engine: one request produces one write or read cycle on the bus.
// Assumes a request is only raised while the engine is idle and LO_CYC >= 2.
module nfc_bus_phy #(
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_rd,
    input  logic       req_cle,
    input  logic       req_ale,
    input  logic [7:0] req_byte,
    output logic       ack,
    output logic [7:0] rd_byte,
    output logic [7:0] io_out,
    output logic       io_oe,
    input  logic [7:0] io_in,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n
);
    localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {P_IDLE, P_LO, P_HI} phy_state_t;

    phy_state_t    st;
    logic [CW-1:0] cnt;
    logic          is_rd;

    // Strobe timing: low phase, sample or release, then recovery high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= P_IDLE;
            cnt     <= '0;
            is_rd   <= 1'b0;
            ack     <= 1'b0;
            rd_byte <= '0;
            io_out  <= '0;
            io_oe   <= 1'b0;
            cle     <= 1'b0;
            ale     <= 1'b0;
            we_n    <= 1'b1;
            re_n    <= 1'b1;
        end else begin
            ack <= 1'b0;
            case (st)
                P_IDLE: if (req) begin
                    st     <= P_LO;
                    cnt    <= '0;
                    is_rd  <= req_rd;
                    cle    <= req_cle;
                    ale    <= req_ale;
                    io_out <= req_byte;
                    io_oe  <= !req_rd;
                    if (req_rd) re_n <= 1'b0;
                    else        we_n <= 1'b0;
                end
                P_LO: if (cnt == CW'(LO_CYC - 1)) begin
                    st   <= P_HI;
                    cnt  <= '0;
                    we_n <= 1'b1;
                    re_n <= 1'b1;
                    if (is_rd) rd_byte <= io_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                P_HI: if (cnt == CW'(HI_CYC - 1)) begin
                    st    <= P_IDLE;
                    ack   <= 1'b1;
                    cle   <= 1'b0;
                    ale   <= 1'b0;
                    io_oe <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= P_IDLE;
            endcase
        end
    end

    // R1
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R1
    we_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !we_n);
    // R1
    re_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |=> !re_n);
    // R1
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);

endmodule

// File: rtl/nand_cmd_seq.sv
// Top: stage sequencer for one NAND command-mode transaction.
// Latches settings on an accepted start, walks the enabled stages in fixed
// order, moves data via the data word or the FIFOs, ends with a done pulse.
// Assumes rb_n is asynchronous (synchronized here) and FIFO_DEPTH is a power of two.
module nand_cmd_seq
    import nfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LO_CYC     = 2,
    parameter int HI_CYC     = 2,
    parameter int WB_CYC     = 4,
    parameter int LEN_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       cmd1_i,
    input  logic [7:0]       cmd2_i,
    input  logic [31:0]      addr_i,
    input  logic [11:0]      ctl_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [31:0]      dreg_wdata_i,
    output logic [31:0]      dreg_rdata_o,
    input  logic             wf_push_i,
    input  logic [7:0]       wf_data_i,
    output logic             wf_full_o,
    input  logic             rf_pop_i,
    output logic [7:0]       rf_data_o,
    output logic             rf_empty_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [7:0]       status_o,
    output logic             err_o,
    output logic [7:0]       io_out,
    output logic             io_oe,
    input  logic [7:0]       io_in,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic             ce_n,
    input  logic             rb_n
);
    localparam int CNT_W   = LEN_W + 1;
    localparam int WB_W    = $clog2(WB_CYC + 1);
    localparam int REG_MAX = 4;

    seq_state_t        st;
    ctl_t              cfg;
    logic [7:0]        c1_q, c2_q;
    logic [31:0]       addr_q, wdat_q;
    logic [CNT_W-1:0]  len_q, bcnt, len_full;
    logic [WB_W-1:0]   wb_cnt;
    logic              pend;
    logic              rb_meta, rb_s;
    logic              rsvd_unused;

    logic              phy_req, phy_rd, phy_cle, phy_ale, phy_ack;
    logic [7:0]        phy_byte, rd_byte;
    logic              issue_st, stall, last_byte;
    logic              wf_pop, wf_empty, rf_push, rf_full;
    logic [7:0]        wf_dout;
    seq_state_t        s_stat, s_post_wait, s_cmd2, s_post_addr, s_post_cmd1;

    assign rsvd_unused = ^ctl_i[11:8];

    // Two-stage synchronizer for the ready/busy line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_meta <= 1'b1;
            rb_s    <= 1'b1;
        end else begin
            rb_meta <= rb_n;
            rb_s    <= rb_meta;
        end
    end

    // Stage successor selection from the latched enables.
    always_comb begin
        s_stat      = cfg.stat_en ? S_STCMD : S_FIN;
        s_post_wait = (!cfg.dir_wr && cfg.data_en) ? S_DATR : s_stat;
        s_cmd2      = cfg.cmd2_en ? S_CMD2 : s_post_wait;
        s_post_addr = (cfg.dir_wr && cfg.data_en) ? S_DATW : s_cmd2;
        s_post_cmd1 = cfg.addr_en ? S_ADDR : s_post_addr;
    end

    // Bus request generation and byte selection for the current stage.
    always_comb begin
        issue_st  = (st == S_CMD1) || (st == S_ADDR) || (st == S_DATW) ||
                    (st == S_CMD2) || (st == S_DATR) || (st == S_STCMD) ||
                    (st == S_STRD);
        stall     = cfg.buf_fifo && (((st == S_DATW) && wf_empty) ||
                                     ((st == S_DATR) && rf_full));
        phy_req   = issue_st && !pend && !stall;
        phy_rd    = (st == S_DATR) || (st == S_STRD);
        phy_cle   = (st == S_CMD1) || (st == S_CMD2) || (st == S_STCMD);
        phy_ale   = (st == S_ADDR);
        last_byte = (bcnt == len_q - 1'b1);
        case (st)
            S_CMD1:  phy_byte = c1_q;
            S_ADDR:  phy_byte = addr_q[{bcnt[1:0], 3'b000} +: 8];
            S_DATW:  phy_byte = cfg.buf_fifo ? wf_dout
                                             : wdat_q[{bcnt[1:0], 3'b000} +: 8];
            S_CMD2:  phy_byte = c2_q;
            S_STCMD: phy_byte = STATUS_CMD;
            default: phy_byte = 8'h00;
        endcase
    end

    assign wf_pop  = (st == S_DATW) && phy_ack && cfg.buf_fifo;
    assign rf_push = (st == S_DATR) && phy_ack && cfg.buf_fifo;

    // Byte count for this start: len+1, limited to the data word in register mode.
    always_comb begin
        len_full = CNT_W'(len_i) + 1'b1;
        if (!ctl_i[6] && (len_full > CNT_W'(REG_MAX)))
            len_full = CNT_W'(REG_MAX);
    end

    // Main stage sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            cfg      <= '0;
            c1_q     <= '0;
            c2_q     <= '0;
            addr_q   <= '0;
            wdat_q   <= '0;
            len_q    <= '0;
            bcnt     <= '0;
            wb_cnt   <= '0;
            pend     <= 1'b0;
            dreg_rdata_o <= '0;
            status_o <= '0;
            err_o    <= 1'b0;
        end else begin
            if (phy_req)      pend <= 1'b1;
            else if (phy_ack) pend <= 1'b0;
            case (st)
                S_IDLE: if (start_i) begin
                    cfg          <= ctl_t'(ctl_i[7:0]);
                    c1_q         <= cmd1_i;
                    c2_q         <= cmd2_i;
                    addr_q       <= addr_i;
                    wdat_q       <= dreg_wdata_i;
                    len_q        <= len_full;
                    bcnt         <= '0;
                    dreg_rdata_o <= '0;
                    status_o     <= '0;
                    err_o        <= 1'b0;
                    st           <= S_CMD1;
                end
                S_CMD1: if (phy_ack) st <= s_post_cmd1;
                S_ADDR: if (phy_ack) begin
                    if (bcnt == CNT_W'(cfg.addr_cnt)) begin
                        bcnt <= '0;
                        st   <= s_post_addr;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                S_DATW: if (phy_ack) begin
                    if (last_byte) begin
                        bcnt <= '0;
                        st   <= s_cmd2;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                S_CMD2: if (phy_ack) begin
                    wb_cnt <= '0;
                    st     <= S_WBDLY;
                end
                S_WBDLY: begin
                    if (wb_cnt == WB_W'(WB_CYC - 1)) st <= S_WAITRB;
                    else wb_cnt <= wb_cnt + 1'b1;
                end
                S_WAITRB: if (rb_s) st <= s_post_wait;
                S_DATR: if (phy_ack) begin
                    if (!cfg.buf_fifo)
                        dreg_rdata_o[{bcnt[1:0], 3'b000} +: 8] <= rd_byte;
                    if (last_byte) begin
                        bcnt <= '0;
                        st   <= s_stat;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                S_STCMD: if (phy_ack) st <= S_STRD;
                S_STRD: if (phy_ack) begin
                    status_o <= rd_byte;
                    err_o    <= rd_byte[0];
                    st       <= S_FIN;
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy_o = (st != S_IDLE);
    assign done_o = (st == S_FIN);
    assign ce_n   = (st == S_IDLE);

    nfc_bus_phy #(.LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_phy (
        .clk(clk), .rst_n(rst_n),
        .req(phy_req), .req_rd(phy_rd), .req_cle(phy_cle), .req_ale(phy_ale),
        .req_byte(phy_byte), .ack(phy_ack), .rd_byte(rd_byte),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n)
    );

    nfc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_wfifo (
        .clk(clk), .rst_n(rst_n),
        .push(wf_push_i), .din(wf_data_i), .pop(wf_pop),
        .dout(wf_dout), .full(wf_full_o), .empty(wf_empty)
    );

    nfc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rfifo (
        .clk(clk), .rst_n(rst_n),
        .push(rf_push), .din(rd_byte), .pop(rf_pop_i),
        .dout(rf_data_o), .full(rf_full), .empty(rf_empty_o)
    );

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(c1_q) && $stable(cfg));
    // R8
    rf_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_push |-> !rf_full);
    // R8
    wf_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wf_pop |-> !wf_empty);
    // R3
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAITRB) |-> (we_n && re_n));

endmodule

// File: tb/sim_nand_cmd_seq.sv
`timescale 1ns/100ps
module sim_nand_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  cmd1_i = '0, cmd2_i = '0;
    logic [31:0] addr_i = '0, dreg_wdata_i = '0;
    logic [11:0] ctl_i = '0;
    logic [3:0]  len_i = '0;
    logic [31:0] dreg_rdata_o;
    logic        wf_push_i = 1'b0, rf_pop_i = 1'b0;
    logic [7:0]  wf_data_i = '0;
    logic        wf_full_o, rf_empty_o, busy_o, done_o, err_o;
    logic [7:0]  rf_data_o, status_o, io_out;
    logic [7:0]  io_in = '0;
    logic        io_oe, cle, ale, we_n, re_n, ce_n;
    logic        rb_n = 1'b1;

    int n_chk = 0, n_bad = 0;
    logic [7:0] lg_b [64];
    logic       lg_c [64];
    logic       lg_a [64];
    int         lg_n = 0;
    logic [7:0] ex_b [64];
    logic       ex_c [64];
    logic       ex_a [64];
    int         ex_n = 0;
    logic [7:0] rdq [32];
    int rptr = 0, n_re = 0, rb_viol = 0, n_done = 0, rbc = 0;
    logic we_prev = 1'b1, re_prev = 1'b1;

    always #2.5 clk = ~clk;

    nand_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd1_i(cmd1_i), .cmd2_i(cmd2_i),
        .addr_i(addr_i), .ctl_i(ctl_i), .len_i(len_i), .dreg_wdata_i(dreg_wdata_i),
        .dreg_rdata_o(dreg_rdata_o), .wf_push_i(wf_push_i), .wf_data_i(wf_data_i),
        .wf_full_o(wf_full_o), .rf_pop_i(rf_pop_i), .rf_data_o(rf_data_o),
        .rf_empty_o(rf_empty_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
        .err_o(err_o), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .cle(cle),
        .ale(ale), .we_n(we_n), .re_n(re_n), .ce_n(ce_n), .rb_n(rb_n)
    );

    // Flash model: logs written bytes, serves read bytes, models busy after 0x10/0x30.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_prev && we_n) begin
                if (lg_n < 64) begin
                    lg_b[lg_n] = io_out; lg_c[lg_n] = cle; lg_a[lg_n] = ale;
                end
                lg_n++;
                if (cle && (io_out == 8'h10 || io_out == 8'h30)) begin
                    rbc = 20; rb_n = 1'b0;
                end
            end else if (rbc > 0) begin
                rbc--;
                if (rbc == 0) rb_n = 1'b1;
            end
            if (re_prev && !re_n) begin
                n_re++;
                if (!rb_n) rb_viol++;
                io_in = rdq[rptr % 32];
                rptr++;
            end
            if (done_o) n_done++;
            we_prev = we_n;
            re_prev = re_n;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic clr();
        lg_n = 0; ex_n = 0; rptr = 0; n_re = 0; rb_viol = 0;
    endtask

    task automatic ex(input logic [7:0] b, input logic c, input logic a);
        ex_b[ex_n] = b; ex_c[ex_n] = c; ex_a[ex_n] = a; ex_n++;
    endtask

    task automatic cmp_log(input string req);
        chk({req, " byte count"}, lg_n, ex_n);
        for (int i = 0; i < ex_n && i < 64; i++)
            chk({req, " bus byte"}, {22'd0, lg_c[i], lg_a[i], lg_b[i]},
                {22'd0, ex_c[i], ex_a[i], ex_b[i]});
    endtask

    task automatic go(input logic [7:0] c1, input logic [7:0] c2, input logic [31:0] ad,
                      input logic [11:0] ctl, input logic [3:0] len, input logic [31:0] wd);
        @(negedge clk);
        cmd1_i = c1; cmd2_i = c2; addr_i = ad; ctl_i = ctl; len_i = len;
        dreg_wdata_i = wd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int d0, input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (n_done > d0) break;
        end
        @(negedge clk);
    endtask

    task automatic push_w(input logic [7:0] b);
        @(negedge clk);
        wf_data_i = b; wf_push_i = 1'b1;
        @(negedge clk);
        wf_push_i = 1'b0;
    endtask

    // R11: idle outputs after reset.
    task automatic t_reset();
        chk("R11 reset state",
            {22'd0, busy_o, done_o, cle, ale, err_o, we_n, re_n, ce_n, 2'b00},
            {22'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00});
        chk("R11 status reset", status_o, 0);
    endtask

    // R1 R2 R4 R5 R6: FIFO write, 3 address bytes, cmd2, status with error bit.
    task automatic t_write_fifo();
        int d0;
        clr();
        rdq[0] = 8'h01;
        for (int i = 0; i < 4; i++) push_w(8'hA0 + 8'(i));
        d0 = n_done;
        go(8'h80, 8'h10, 32'h44332211, 12'h0FD, 4'd3, 32'h0);
        wait_done(d0, 2000);
        ex(8'h80, 1, 0); ex(8'h11, 0, 1); ex(8'h22, 0, 1); ex(8'h33, 0, 1);
        for (int i = 0; i < 4; i++) ex(8'hA0 + 8'(i), 0, 0);
        ex(8'h10, 1, 0); ex(8'h70, 1, 0);
        cmp_log("R5 write order");
        chk("R4 status byte", status_o, 32'h01);
        chk("R4 error flag", err_o, 1);
        chk("R3 no read while busy", rb_viol, 0);
        chk("R1 status read strobes", n_re, 1);
    endtask

    // R6 R3 R10: register read, no address, with reserved bits given.
    task automatic t_read_reg(input logic [3:0] rsvd);
        int d0;
        clr();
        rdq[0] = 8'h5A; rdq[1] = 8'hC3;
        d0 = n_done;
        go(8'h00, 8'h30, 32'hFFFFFFFF, {rsvd, 8'h88}, 4'd1, 32'h0);
        wait_done(d0, 2000);
        ex(8'h00, 1, 0); ex(8'h30, 1, 0);
        cmp_log(rsvd != 0 ? "R10 reserved set log" : "R2 no address stage");
        chk(rsvd != 0 ? "R10 reserved set data" : "R6 register read", dreg_rdata_o, 32'h0000C35A);
        chk("R3 read waits for ready", rb_viol, 0);
        chk("R4 no status when disabled", {23'd0, err_o, status_o}, 0);
        chk("R7 read strobe count", n_re, 2);
    endtask

    // R8: read FIFO fills, sequencer stalls, resumes on pops.
    task automatic t_read_stall();
        int d0, got;
        logic [7:0] vals [16];
        clr();
        got = 0;
        for (int i = 0; i < 16; i++) rdq[i] = 8'h40 + 8'(i);
        d0 = n_done;
        go(8'h00, 8'h30, 32'h0D0C0B0A, 12'h0CF, 4'd11, 32'h0);
        for (int i = 0; i < 3000 && n_re < 8; i++) @(negedge clk);
        repeat (60) @(negedge clk);
        chk("R8 stall on full read FIFO", n_re, 8);
        chk("R8 busy during stall", busy_o, 1);
        for (int i = 0; i < 3000 && got < 12; i++) begin
            @(negedge clk);
            if (!rf_empty_o) begin
                vals[got] = rf_data_o; got++; rf_pop_i = 1'b1;
            end else begin
                rf_pop_i = 1'b0;
            end
        end
        @(negedge clk);
        rf_pop_i = 1'b0;
        wait_done(d0, 2000);
        chk("R7 read FIFO byte count", got, 12);
        for (int i = 0; i < 12; i++) chk("R6 read FIFO order", vals[i], 8'h40 + 8'(i));
        ex(8'h00, 1, 0);
        for (int i = 0; i < 4; i++) ex(8'h0A + 8'(i), 0, 1);
        ex(8'h30, 1, 0);
        cmp_log("R2 four address bytes");
        chk("R3 read waits for ready", rb_viol, 0);
    endtask

    // R8 R3: write FIFO empty stalls data; no second command, no wait.
    task automatic t_write_stall();
        int d0;
        clr();
        d0 = n_done;
        go(8'h85, 8'h10, 32'h00000077, 12'h0E1, 4'd1, 32'h0);
        repeat (80) @(negedge clk);
        chk("R8 stall on empty write FIFO", lg_n, 2);
        chk("R8 busy during stall", busy_o, 1);
        push_w(8'hB1); push_w(8'hB2);
        wait_done(d0, 2000);
        ex(8'h85, 1, 0); ex(8'h77, 0, 1); ex(8'hB1, 0, 0); ex(8'hB2, 0, 0);
        cmp_log("R3 no second command");
        chk("R3 no busy wait raised", rb_n, 1);
    endtask

    // R6 R9: register write clamped to 4 bytes; start while busy ignored.
    task automatic t_write_reg();
        int d0;
        clr();
        rdq[0] = 8'hE0;
        d0 = n_done;
        go(8'h80, 8'h10, 32'h00003412, 12'h0BB, 4'd9, 32'hDDCCBBAA);
        chk("R9 busy after start", busy_o, 1);
        repeat (5) @(negedge clk);
        go(8'hFF, 8'hEE, 32'h0, 12'h080, 4'd0, 32'h0);
        wait_done(d0, 2000);
        chk("R9 single done pulse", n_done - d0, 1);
        chk("R9 idle after done", busy_o, 0);
        ex(8'h80, 1, 0); ex(8'h12, 0, 1); ex(8'h34, 0, 1);
        ex(8'hAA, 0, 0); ex(8'hBB, 0, 0); ex(8'hCC, 0, 0); ex(8'hDD, 0, 0);
        ex(8'h10, 1, 0); ex(8'h70, 1, 0);
        cmp_log("R9 start ignored, R6 clamp");
        chk("R4 status clear bit 0", {23'd0, err_o, status_o}, 32'h0E0);
    endtask

    // R7 R4: one-byte register read; then status-only transaction.
    task automatic t_short();
        int d0;
        clr();
        rdq[0] = 8'h9C;
        d0 = n_done;
        go(8'h05, 8'h00, 32'h0, 12'h080, 4'd0, 32'h0);
        wait_done(d0, 2000);
        ex(8'h05, 1, 0);
        cmp_log("R7 single byte read");
        chk("R7 single byte data", dreg_rdata_o, 32'h0000009C);
        clr();
        rdq[0] = 8'h3E;
        d0 = n_done;
        go(8'hFF, 8'h00, 32'h0, 12'h010, 4'd0, 32'h0);
        wait_done(d0, 2000);
        ex(8'hFF, 1, 0); ex(8'h70, 1, 0);
        cmp_log("R4 status only");
        chk("R4 status no error", {23'd0, err_o, status_o}, 32'h03E);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_fifo();
        t_read_reg(4'hF);
        t_read_reg(4'h0);
        t_read_stall();
        t_write_stall();
        t_write_reg();
        t_short();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule